// File: doc/BRIEF.md
# 16-Pin GPIO Expander Register Bank

This block holds the configuration registers and pin logic of a sixteen-pin general-purpose I/O expander. A host reaches it through a simple byte-wide port with an address, write data, a write strobe, a read strobe and registered read data. The serial front end sits outside this block. For each pin the block keeps six bits: direction, output latch, pull-up enable, pull-down enable, open-drain enable and read polarity. It turns them into pad output-value, output-enable and pull-enable vectors. It also reads the pad input vector back as the data register.

Each 16-bit setting is stored as two byte registers at adjacent addresses. Pins 15..8 sit at the lower address of the pair and pins 7..0 at the higher one. The block also has a clock-control register that drives one extra oscillator-capable pin, and a general byte register for miscellaneous settings. A two-byte key written in sequence to a reset register returns every register to its power-up value without using the hardware reset.

Top module: `gpx16_regbank`

## Requirements
- R1: After `rst_n` is released, all pins are inputs (`pad_oe` = 0). The output latches, pull enables, open-drain, polarity, clock-control and miscellaneous registers are 0, and both direction bytes read back 0xFF.
- R2: The byte pairs (high pins, low pins) are: pull-up 0x06/0x07, pull-down 0x08/0x09, open-drain 0x0A/0x0B, polarity 0x0C/0x0D, direction 0x0E/0x0F and data 0x10/0x11. Configuration bytes read back as written, and `pad_pu`/`pad_pd` follow the pull-up and pull-down pairs.
- R3: A direction bit of 1 makes the pin an input (`pad_oe` bit 0). A direction bit of 0 makes it an output that drives its latch value on `pad_out` with `pad_oe` set.
- R4: Writing 0x10/0x11 loads the output latches. Reading 0x10/0x11 returns the pad level on `pad_in`, not the latch.
- R5: A polarity bit of 1 inverts the value read back for that pin. It has no effect on `pad_out` or `pad_oe`.
- R6: An output pin with its open-drain bit set never drives high. For a latch of 0 it drives 0 with `pad_oe` set. For a latch of 1 it releases the pad (`pad_oe` bit 0).
- R7: The clock-control register at 0x1E reads back as written. The oscillator pin `osc_out` equals bit 4 AND bit 0 of that register, so 0x1F drives it high and 0x10 drives it low.
- R8: The miscellaneous register at 0x1F stores any byte and reads it back.
- R9: Writing 0x12 and then 0x34 to 0x7D restores all registers to their R1 values. The key still counts if idle cycles with no write fall between the two bytes.
- R10: Any write other than 0x34 to 0x7D cancels a pending key. A write of 0x12 to 0x7D always arms the key afresh.
- R11: Reading any address outside 0x06..0x11, 0x1E and 0x1F returns 0x00, including 0x7D. Writing such an address changes no register or pad output.
- R12: `rdata` takes the addressed value at the clock edge where `rd_en` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pad_in | input | 16 | Sensed pad levels |
| pad_out | output | 16 | Pad output values |
| pad_oe | output | 16 | Pad output enables |
| pad_pu | output | 16 | Pull-up enables |
| pad_pd | output | 16 | Pull-down enables |
| osc_out | output | 1 | Oscillator-capable pin level |

## Verification
The bench writes distinct patterns into each half of a pair. A design that swapped the byte order would show the patterns on the wrong pins of `pad_pu` and `pad_oe`. The data register is read while the latch and the external pad level differ, and with polarity set, which catches a design that returns the latch or inverts the outputs. The reset key is tried with an intervening write to another register, with a wrong second byte and with idle gaps. A design that kept a stale armed key would clear the registers when it should not, and one that needed back-to-back bytes would miss a valid sequence. Unmapped reads and writes, including the key register, are checked for a zero result and unchanged pads.

// File: rtl/gpx16_regbank.sv
module gpx16_regbank #(
  parameter logic [7:0] KEY_FIRST  = 8'h12,
  parameter logic [7:0] KEY_SECOND = 8'h34
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [7:0]  rdata,
  input  logic [15:0] pad_in,
  output logic [15:0] pad_out,
  output logic [15:0] pad_oe,
  output logic [15:0] pad_pu,
  output logic [15:0] pad_pd,
  output logic        osc_out
);
  localparam logic [7:0] A_PU   = 8'h06;
  localparam logic [7:0] A_PD   = 8'h08;
  localparam logic [7:0] A_OD   = 8'h0A;
  localparam logic [7:0] A_POL  = 8'h0C;
  localparam logic [7:0] A_DIR  = 8'h0E;
  localparam logic [7:0] A_DAT  = 8'h10;
  localparam logic [7:0] A_CLK  = 8'h1E;
  localparam logic [7:0] A_MISC = 8'h1F;
  localparam logic [7:0] A_KEY  = 8'h7D;

  logic [15:0] pu_q, pd_q, od_q, pol_q, dir_q, dat_q;
  logic [7:0]  clk_q, misc_q, rdata_q, rd_val;
  logic        key_q;

  wire key_hit = wr_en && addr == A_KEY && wdata == KEY_SECOND && key_q;
  wire [15:0] level = pad_in ^ pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= 1'b0;
    else if (wr_en) key_q <= (addr == A_KEY) && (wdata == KEY_FIRST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pu_q <= '0; pd_q <= '0; od_q <= '0; pol_q <= '0;
      dir_q <= '1; dat_q <= '0; clk_q <= '0; misc_q <= '0;
    end else if (key_hit) begin
      pu_q <= '0; pd_q <= '0; od_q <= '0; pol_q <= '0;
      dir_q <= '1; dat_q <= '0; clk_q <= '0; misc_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PU:       pu_q[15:8]  <= wdata;
        A_PU + 1:   pu_q[7:0]   <= wdata;
        A_PD:       pd_q[15:8]  <= wdata;
        A_PD + 1:   pd_q[7:0]   <= wdata;
        A_OD:       od_q[15:8]  <= wdata;
        A_OD + 1:   od_q[7:0]   <= wdata;
        A_POL:      pol_q[15:8] <= wdata;
        A_POL + 1:  pol_q[7:0]  <= wdata;
        A_DIR:      dir_q[15:8] <= wdata;
        A_DIR + 1:  dir_q[7:0]  <= wdata;
        A_DAT:      dat_q[15:8] <= wdata;
        A_DAT + 1:  dat_q[7:0]  <= wdata;
        A_CLK:      clk_q       <= wdata;
        A_MISC:     misc_q      <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_PU:      rd_val = pu_q[15:8];
      A_PU + 1:  rd_val = pu_q[7:0];
      A_PD:      rd_val = pd_q[15:8];
      A_PD + 1:  rd_val = pd_q[7:0];
      A_OD:      rd_val = od_q[15:8];
      A_OD + 1:  rd_val = od_q[7:0];
      A_POL:     rd_val = pol_q[15:8];
      A_POL + 1: rd_val = pol_q[7:0];
      A_DIR:     rd_val = dir_q[15:8];
      A_DIR + 1: rd_val = dir_q[7:0];
      A_DAT:     rd_val = level[15:8];
      A_DAT + 1: rd_val = level[7:0];
      A_CLK:     rd_val = clk_q;
      A_MISC:    rd_val = misc_q;
      default:   rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 8'h00;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata   = rdata_q;
  assign pad_oe  = ~dir_q & ~(od_q & dat_q);
  assign pad_out = dat_q & ~od_q;
  assign pad_pu  = pu_q;
  assign pad_pd  = pd_q;
  assign osc_out = clk_q[4] & clk_q[0];
endmodule

// File: rtl/gpx16_regbank_chk.sv
module gpx16_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  addr,
  input logic [7:0]  wdata,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  rdata,
  input logic [15:0] pad_out,
  input logic [15:0] pad_oe,
  input logic        osc_out
);
  wire mapped = (addr >= 8'h06 && addr <= 8'h11) || addr == 8'h1E || addr == 8'h1F;

  assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == 16'h0 && !osc_out));

  assert_dir_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h0F && wdata == 8'hFF) |=> (pad_oe[7:0] == 8'h00));

  assert_od_no_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h0B && wdata == 8'hFF) |=> ((pad_out[7:0] & pad_oe[7:0]) == 8'h00));

  assert_osc_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h1E && wdata == 8'h1F) |=> osc_out);

  assert_key_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h7D && wdata == 8'h34 &&
     $past(wr_en && addr == 8'h7D && wdata == 8'h12)) |=> (pad_oe == 16'h0 && !osc_out));

  assert_unmapped_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> (rdata == 8'h00));

  assert_unmapped_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped && addr != 8'h7D) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(osc_out)));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind gpx16_regbank gpx16_regbank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .osc_out(osc_out)
);

// File: tb/gpx16_regbank_tb_top.sv
`timescale 1ns/1ps
module gpx16_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] ext = '0;
  logic [15:0] pad_in, pad_out, pad_oe, pad_pu, pad_pd;
  logic        osc_out;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpx16_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .osc_out(osc_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 pad_oe", pad_oe, 16'h0);
    chk("R1 osc_out", osc_out, 1'b0);
    chk("R1 pad_pu", pad_pu, 16'h0);
    rd(8'h0E, v); chk("R1 dir hi", v, 8'hFF);
    rd(8'h0F, v); chk("R1 dir lo", v, 8'hFF);
    rd(8'h0A, v); chk("R1 od hi", v, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] v;
    wr(8'h06, 8'hA5); wr(8'h07, 8'h3C);
    wr(8'h08, 8'h81); wr(8'h09, 8'h7E);
    chk("R2 pad_pu", pad_pu, 16'hA53C);
    chk("R2 pad_pd", pad_pd, 16'h817E);
    rd(8'h06, v); chk("R2 pu hi read", v, 8'hA5);
    rd(8'h09, v); chk("R2 pd lo read", v, 8'h7E);
  endtask

  task automatic t_dir_data();
    logic [7:0] v;
    ext = 16'h00AA;
    wr(8'h10, 8'hF0); wr(8'h11, 8'h0F);
    chk("R3 still inputs", pad_oe, 16'h0);
    wr(8'h0E, 8'h00);
    chk("R3 high pins output", pad_oe, 16'hFF00);
    chk("R3 driven value", pad_out & pad_oe, 16'hF000);
    rd(8'h10, v); chk("R4 read hi level", v, 8'hF0);
    rd(8'h11, v); chk("R4 read lo pad not latch", v, 8'hAA);
  endtask

  task automatic t_polarity();
    logic [7:0] v;
    wr(8'h0D, 8'hFF);
    rd(8'h11, v); chk("R5 inverted read", v, 8'h55);
    rd(8'h10, v); chk("R5 hi unaffected", v, 8'hF0);
    chk("R5 pad_oe unchanged", pad_oe, 16'hFF00);
    chk("R5 pad_out unchanged", pad_out & pad_oe, 16'hF000);
  endtask

  task automatic t_open_drain();
    wr(8'h0A, 8'hFF);
    chk("R6 od releases highs", pad_oe, 16'h0F00);
    chk("R6 od drives low only", pad_out & pad_oe, 16'h0000);
    wr(8'h0A, 8'h00);
    chk("R6 push-pull restored", pad_oe, 16'hFF00);
  endtask

  task automatic t_osc_misc();
    logic [7:0] v;
    wr(8'h1E, 8'h1F); chk("R7 osc high", osc_out, 1'b1);
    rd(8'h1E, v); chk("R7 clock readback", v, 8'h1F);
    wr(8'h1E, 8'h10); chk("R7 osc low", osc_out, 1'b0);
    wr(8'h1F, 8'h5A);
    rd(8'h1F, v); chk("R8 misc readback", v, 8'h5A);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    rd(8'h20, v); chk("R11 read 0x20", v, 8'h00);
    rd(8'h05, v); chk("R11 read 0x05", v, 8'h00);
    rd(8'h7D, v); chk("R11 read key reg", v, 8'h00);
    wr(8'h12, 8'hFF); wr(8'h05, 8'hFF); wr(8'h1D, 8'hFF);
    chk("R11 pad_oe unchanged", pad_oe, 16'hFF00);
    chk("R11 pad_pu unchanged", pad_pu, 16'hA53C);
    rd(8'h07, v); chk("R11 pu lo unchanged", v, 8'h3C);
  endtask

  task automatic t_read_hold();
    logic [7:0] v;
    rd(8'h06, v);
    addr = 8'h1F;
    @(negedge clk); @(negedge clk);
    chk("R12 rdata held", rdata, 8'hA5);
  endtask

  task automatic t_key_cancel();
    wr(8'h7D, 8'h12); wr(8'h1F, 8'h00); wr(8'h7D, 8'h34);
    chk("R10 other write cancels", pad_oe, 16'hFF00);
    wr(8'h7D, 8'h12); wr(8'h7D, 8'h56); wr(8'h7D, 8'h34);
    chk("R10 wrong byte cancels", pad_oe, 16'hFF00);
    chk("R10 pulls kept", pad_pu, 16'hA53C);
  endtask

  task automatic t_key_reset();
    logic [7:0] v;
    wr(8'h1E, 8'h1F);
    wr(8'h7D, 8'h12); wr(8'h7D, 8'h12);
    repeat (3) @(negedge clk);
    wr(8'h7D, 8'h34);
    chk("R9 pad_oe cleared", pad_oe, 16'h0);
    chk("R9 pad_pu cleared", pad_pu, 16'h0);
    chk("R9 osc cleared", osc_out, 1'b0);
    rd(8'h0E, v); chk("R9 dir default", v, 8'hFF);
    rd(8'h1F, v); chk("R9 misc cleared", v, 8'h00);
    ext = 16'h0000;
    rd(8'h11, v); chk("R9 polarity cleared", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_dir_data();
    t_polarity();
    t_open_drain();
    t_osc_misc();
    t_unmapped();
    t_read_hold();
    t_key_cancel();
    t_key_reset();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule